// File: doc/BRIEF.md
# Address-Folded SECDED Word Guard

This block protects a 32-bit word memory path from the requesting side to the storage array and back. On a write it builds eight check bits: seven Hamming parity bits and one overall parity bit. The parity equations take in the write data and the word address together. The check bits go to storage next to the data, exactly as produced. The memory does not encode the word a second time. Address bits are never stored. They only steer the parity.

On a read the block remembers the requested address and recomputes the code over the returned data and that address. It compares the result with the stored check bits. A single flipped data bit is repaired. A single flipped check bit is tolerated. Two flipped bits are reported as uncorrectable. A word that comes back from the wrong location, differing from the requested address in one bit, is reported as an address error.

An injection input flips one chosen bit of the word on its way to storage, so correction and detection can be exercised on demand.

Top module: `addr_fold_secded`

## Requirements
- R1: After reset, with no request, rspValid, errCorrected, errUncorrectable and errAddress are all 0.
- R2: A write request (reqValid=1, reqWrite=1) drives memEn=1, memWe=1, memAddr=reqAddr and memWdata in the same cycle. The stored word layout is bits 31:0 data, bits 38:32 Hamming parity, bit 39 overall parity. Without injection, the XOR of all 40 stored bits and all address bits is 0.
- R3: A read request sampled at a clock edge produces rspValid=1 for exactly one cycle, after the second following edge. A write request produces no response.
- R4: A read whose stored word and address are intact returns the written data with all three error flags at 0.
- R5: One flipped stored data bit is corrected. rspData equals the written data and errCorrected=1.
- R6: One flipped Hamming bit (stored bits 38:32) or a flipped overall bit (bit 39) leaves rspData equal to the written data and sets errCorrected=1.
- R7: Two flipped stored bits set errUncorrectable=1. rspData is the raw stored data, with no correction applied.
- R8: A word written at one address and returned for a request whose address differs from it in exactly one bit sets errAddress=1, and rspData is the raw stored data. A difference in two address bits sets errUncorrectable=1.
- R9: With injEn=1 during a write, stored bit injSel (0 to 39) is inverted. An injSel of 40 or more inverts nothing. The check bits of a given data word differ between two addresses.
- R10: At most one error flag is high at a time, and a flag is high only while rspValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 10 | Word address |
| reqWdata | input | 32 | Write data |
| injEn | input | 1 | Enable single-bit injection on the write word |
| injSel | input | 6 | Stored bit to invert |
| memEn | output | 1 | Storage access enable |
| memWe | output | 1 | Storage write enable |
| memAddr | output | 10 | Storage address |
| memWdata | output | 40 | Stored word: data, Hamming bits, overall bit |
| memRdata | input | 40 | Stored word returned one cycle after a read access |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Read data, corrected when possible |
| errCorrected | output | 1 | Single-bit error repaired or tolerated |
| errUncorrectable | output | 1 | Multi-bit error |
| errAddress | output | 1 | Word came from a location other than the requested one |

## Verification
Each read is tried against several kinds of stored words. Clean words with all-zero, all-one and mixed data show that no flag is raised when nothing is wrong. A single flip at the lowest and highest data bits, at the lowest and highest Hamming bits and at the overall bit separates data repair from tolerated check-bit faults. Flip pairs in data/data and data/check combinations must never be miscorrected. A location alias with one differing address bit must give an address error, while two differing bits must give an uncorrectable error. Out-of-range injection must change nothing. The same data written at two addresses must get different check bits, and read, write and back-to-back response timing is measured cycle by cycle.

// File: rtl/afsec_pkg.sv
package afsec_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int HAM_W  = 7;
  localparam int INFO_W = DATA_W + ADDR_W;
  localparam int CW_W   = DATA_W + HAM_W + 1;
  localparam int SEL_W  = $clog2(CW_W);

  // Strobes from control to datapath
  typedef struct packed {
    logic write;    // write request this cycle
    logic capture;  // latch read address
    logic respond;  // memory word for a pending read is present
  } strobe_t;

  typedef enum logic [1:0] {K_CLEAN, K_CORR, K_UNC, K_ADDR} kind_e;

  // Hamming position of information bit idx (data first, then address),
  // skipping power-of-two positions reserved for parity bits.
  function automatic logic [HAM_W-1:0] posOf(input int idx);
    int cnt;
    logic [HAM_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = HAM_W'(p);
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/afsec_encode.sv
module afsec_encode
  import afsec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [HAM_W-1:0]  ham,
  output logic              ovr
);
  logic [INFO_W-1:0] info;
  assign info = {addr, data};

  always_comb begin
    logic [HAM_W-1:0] pos;
    ham = '0;
    for (int i = 0; i < INFO_W; i++) begin
      pos = posOf(i);
      for (int j = 0; j < HAM_W; j++) begin
        if (pos[j]) ham[j] = ham[j] ^ info[i];
      end
    end
  end

  assign ovr = ^{info, ham};
endmodule

// File: rtl/afsec_ctrl.sv
module afsec_ctrl
  import afsec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    memEn,
  output logic    memWe,
  output strobe_t strobe
);
  logic pendValid;

  always_ff @(posedge clk) begin
    if (!rstN) pendValid <= 1'b0;
    else       pendValid <= reqValid && !reqWrite;
  end

  assign memEn          = reqValid;
  assign memWe          = reqValid && reqWrite;
  assign strobe.write   = reqValid && reqWrite;
  assign strobe.capture = reqValid && !reqWrite;
  assign strobe.respond = pendValid;
endmodule

// File: rtl/afsec_datapath.sv
module afsec_datapath
  import afsec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              injEn,
  input  logic [SEL_W-1:0]  injSel,
  output logic [CW_W-1:0]   memWdata,
  input  logic [CW_W-1:0]   memRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              errCorrected,
  output logic              errUncorrectable,
  output logic              errAddress
);
  // Write side: encode and optionally invert one stored bit
  logic [HAM_W-1:0] wrHam;
  logic             wrOvr;
  logic [CW_W-1:0]  injMask;

  afsec_encode u_enc_wr (.data(reqWdata), .addr(reqAddr), .ham(wrHam), .ovr(wrOvr));

  assign injMask  = (injEn && (int'(injSel) < CW_W)) ? (CW_W'(1) << injSel) : '0;
  assign memWdata = {wrOvr, wrHam, reqWdata} ^ injMask;

  // Read side: recompute over returned data and the requested address
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] rdData;
  logic [HAM_W-1:0]  rdHam, reHam, syn;
  logic              rdOvr, reOvr, parOdd;

  always_ff @(posedge clk) begin
    if (!rstN)               pendAddr <= '0;
    else if (strobe.capture) pendAddr <= reqAddr;
  end

  assign rdData = memRdata[DATA_W-1:0];
  assign rdHam  = memRdata[DATA_W +: HAM_W];
  assign rdOvr  = memRdata[CW_W-1];

  afsec_encode u_enc_rd (.data(rdData), .addr(pendAddr), .ham(reHam), .ovr(reOvr));

  assign syn    = reHam ^ rdHam;
  assign parOdd = reOvr ^ (^syn) ^ rdOvr;

  kind_e             kind;
  logic [DATA_W-1:0] outData;

  always_comb begin
    logic dataHit, addrHit;
    logic [DATA_W-1:0] fix;
    dataHit = 1'b0;
    addrHit = 1'b0;
    fix     = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (syn == posOf(i)) begin
        dataHit = 1'b1;
        fix[i]  = 1'b1;
      end
    end
    for (int i = DATA_W; i < INFO_W; i++) begin
      if (syn == posOf(i)) addrHit = 1'b1;
    end
    outData = rdData;
    if (syn == '0)                   kind = parOdd ? K_CORR : K_CLEAN;
    else if (!parOdd)                kind = K_UNC;
    else if ((syn & (syn - 1)) == 0) kind = K_CORR;
    else if (dataHit) begin
      kind    = K_CORR;
      outData = rdData ^ fix;
    end
    else if (addrHit)                kind = K_ADDR;
    else                             kind = K_UNC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid         <= 1'b0;
      rspData          <= '0;
      errCorrected     <= 1'b0;
      errUncorrectable <= 1'b0;
      errAddress       <= 1'b0;
    end else begin
      rspValid         <= strobe.respond;
      errCorrected     <= strobe.respond && (kind == K_CORR);
      errUncorrectable <= strobe.respond && (kind == K_UNC);
      errAddress       <= strobe.respond && (kind == K_ADDR);
      if (strobe.respond) rspData <= outData;
    end
  end

  // R2
  enc_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !injEn) |-> ((^{memWdata, reqAddr}) == 1'b0));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errCorrected, errUncorrectable, errAddress}));
  // R10
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCorrected || errUncorrectable || errAddress) |-> rspValid);
  // R7
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errUncorrectable || errAddress) |-> (rspData == $past(rdData)));
endmodule

// File: rtl/addr_fold_secded.sv
module addr_fold_secded
  import afsec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              injEn,
  input  logic [SEL_W-1:0]  injSel,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CW_W-1:0]   memWdata,
  input  logic [CW_W-1:0]   memRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              errCorrected,
  output logic              errUncorrectable,
  output logic              errAddress
);
  strobe_t strobe;

  assign memAddr = reqAddr;

  afsec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .memEn(memEn), .memWe(memWe), .strobe(strobe)
  );

  afsec_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .injEn(injEn), .injSel(injSel),
    .memWdata(memWdata), .memRdata(memRdata), .rspValid(rspValid),
    .rspData(rspData), .errCorrected(errCorrected),
    .errUncorrectable(errUncorrectable), .errAddress(errAddress)
  );

  // R3
  read_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> ##1 rspValid);
  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> ##1 !rspValid);
endmodule

// File: tb/sim_addr_fold_secded.sv
module sim_addr_fold_secded;
  import afsec_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic              reqValid = 1'b0, reqWrite = 1'b0, injEn = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [SEL_W-1:0]  injSel = '0;
  logic              memEn, memWe, rspValid, errC, errU, errA;
  logic [ADDR_W-1:0] memAddr;
  logic [CW_W-1:0]   memWdata, memRdata;
  logic [DATA_W-1:0] rspData;

  // behavioural storage with alias and corruption knobs
  logic [CW_W-1:0]   ram [1 << ADDR_W];
  logic [ADDR_W-1:0] aliasMask = '0;
  logic [CW_W-1:0]   flipMask = '0;

  always @(posedge clk) begin
    if (memEn && memWe)  ram[memAddr] <= memWdata;
    if (memEn && !memWe) memRdata <= ram[memAddr ^ aliasMask] ^ flipMask;
  end

  addr_fold_secded u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .injEn(injEn), .injSel(injSel),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rspValid(rspValid), .rspData(rspData),
    .errCorrected(errC), .errUncorrectable(errU), .errAddress(errA)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flag code: 0 clean, 1 corrected, 2 uncorrectable, 3 address
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              inj;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  flip2;  // 63 = none
    logic [ADDR_W-1:0] alias_;
    logic [1:0]        flag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{10'h001, 32'hA5A5_5A5A, 1'b0, 6'd0,  6'd63, 10'h000, 2'd0}, // R4
    '{10'h3FF, 32'hFFFF_FFFF, 1'b0, 6'd0,  6'd63, 10'h000, 2'd0}, // R4
    '{10'h000, 32'h0000_0000, 1'b0, 6'd0,  6'd63, 10'h000, 2'd0}, // R4
    '{10'h155, 32'hDEAD_BEEF, 1'b1, 6'd0,  6'd63, 10'h000, 2'd1}, // R5
    '{10'h2AA, 32'h1234_5678, 1'b1, 6'd31, 6'd63, 10'h000, 2'd1}, // R5
    '{10'h010, 32'hCAFE_F00D, 1'b1, 6'd32, 6'd63, 10'h000, 2'd1}, // R6
    '{10'h011, 32'h0F0F_0F0F, 1'b1, 6'd38, 6'd63, 10'h000, 2'd1}, // R6
    '{10'h012, 32'h8000_0001, 1'b1, 6'd39, 6'd63, 10'h000, 2'd1}, // R6
    '{10'h013, 32'h5555_AAAA, 1'b1, 6'd3,  6'd17, 10'h000, 2'd2}, // R7
    '{10'h014, 32'h7777_1111, 1'b1, 6'd5,  6'd35, 10'h000, 2'd2}, // R7
    '{10'h020, 32'h1357_9BDF, 1'b0, 6'd0,  6'd63, 10'h001, 2'd3}, // R8
    '{10'h021, 32'h2468_ACE0, 1'b0, 6'd0,  6'd63, 10'h200, 2'd3}, // R8
    '{10'h022, 32'hFACE_B00C, 1'b0, 6'd0,  6'd63, 10'h003, 2'd2}, // R8
    '{10'h023, 32'h0BAD_F00D, 1'b1, 6'd45, 6'd63, 10'h000, 2'd0}  // R9
  };

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic ie, input logic [SEL_W-1:0] s);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; injEn = ie; injSel = s;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; injEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW_W-1:0] m;
    logic [HAM_W-1:0] hamA;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 flags", 64'({errA, errU, errC}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 64'({rspValid, errA, errU, errC}), 64'd0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [CW_W-1:0] injM, f2M;
      logic [DATA_W-1:0] expD;
      logic [2:0] expF;
      t = VT[v];
      injM = (t.inj && t.sel < 6'd40) ? (CW_W'(1) << t.sel) : '0;
      f2M  = (t.flip2 < 6'd40) ? (CW_W'(1) << t.flip2) : '0;
      // write, checking the stored word in the request cycle
      @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = t.addr; reqWdata = t.data;
      injEn = t.inj; injSel = t.sel;
      #1;
      chk($sformatf("R2 strobes v%0d", v), 64'({memEn, memWe, memAddr}), 64'({2'b11, t.addr}));
      chk($sformatf("R2 data field v%0d", v), 64'(memWdata[31:0]), 64'(t.data ^ injM[31:0]));
      chk($sformatf("R9 stored parity v%0d", v), 64'(^{memWdata, memAddr}), 64'(|injM));
      @(negedge clk);
      reqValid = 1'b0; reqWrite = 1'b0; injEn = 1'b0;
      flipMask = f2M;
      aliasMask = t.alias_;
      doRead(t.addr ^ t.alias_);
      expD = (t.flag >= 2'd2) ? (t.data ^ injM[31:0] ^ f2M[31:0]) : t.data;
      expF = (t.flag == 2'd0) ? 3'b000 : (3'b001 << (t.flag - 2'd1));
      chk($sformatf("R3 rspValid v%0d", v), 64'(rspValid), 64'd1);
      chk($sformatf("R4-type data v%0d", v), 64'(rspData), 64'(expD));
      chk($sformatf("R5/R6/R7/R8 flags v%0d", v), 64'({errA, errU, errC}), 64'(expF));
      flipMask = '0;
      aliasMask = '0;
    end

    // R3 timing: response exactly after second edge, single cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 10'h001;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3 not after first edge", 64'(rspValid), 64'd0);
    @(negedge clk);
    chk("R3 valid after second edge", 64'(rspValid), 64'd1);
    @(negedge clk);
    chk("R3 single cycle pulse", 64'(rspValid), 64'd0);

    // R3 back-to-back reads give back-to-back responses
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 10'h001;
    @(negedge clk);
    reqAddr = 10'h3FF;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R3 first of pair", 64'({rspValid, rspData}), {31'd0, 1'b1, 32'hA5A5_5A5A});
    @(negedge clk);
    chk("R3 second of pair", 64'({rspValid, rspData}), {31'd0, 1'b1, 32'hFFFF_FFFF});

    // R3 write gives no response
    doWrite(10'h050, 32'h1111_2222, 1'b0, '0);
    chk("R3 write quiet", 64'(rspValid), 64'd0);
    @(negedge clk);
    chk("R3 write quiet later", 64'(rspValid), 64'd0);

    // R9 check bits depend on address
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 10'h001; reqWdata = 32'h600D_CAFE;
    #1 m = memWdata; hamA = m[38:32];
    @(negedge clk);
    reqAddr = 10'h002;
    #1;
    chk("R9 address folded into check bits", 64'(hamA != memWdata[38:32]), 64'd1);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;

    // R10 idle flags stay low
    @(negedge clk);
    chk("R10 flags idle", 64'({rspValid, errA, errU, errC}), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule